// File: doc/BRIEF.md
# State Identifier Allocation Counter

This block hands out state identifiers at the rename stage to a group of up to four decoded instructions per cycle. The lanes are numbered 0 to 3 in program order. A lane opens a new state only if it is valid and writes a destination register. Such a lane receives the running counter plus its rank among the register-writing lanes of the group, where the first writer has rank 1. A lane that writes no register, such as a branch or a store, reuses the identifier of the closest earlier writer, or the running counter when no earlier lane in the group writes. The block also presents the counter value that follows the group. The counter commits that value only when the group is accepted, which means no stall and no recovery load.

Identifiers are log2(M)+1 bits wide for M physical registers. The top bit is a saturation bit. The counter counts up from zero to all ones. When a group would pass all ones, every identifier of that group and the following counter value are lowered by M. Lanes before the wrap point therefore come out with the saturation bit cleared, and lanes after it continue upward from M. In the same cycle a one-cycle pulse tells every table that holds identifiers to clear their saturation bits. On recovery the counter is loaded from a recovery identifier. For an exception raised by an instruction that itself opened a state, the counter is loaded with that identifier minus one.

Top module: `stid_alloc`

## Requirements
- R1: After reset the counter is zero, so a group with no register writers shows identifier 0 on every lane and a next value of 0.
- R2: A register-writing lane gets the counter plus the number of writer lanes from lane 0 up to and including itself. A non-writing lane gets the same value as the lane before it, or the counter for lane 0. Lane i occupies bits [9i+8:9i] of `laneIds` at the default M=256.
- R3: A lane whose `laneValid` bit is 0 never counts as a writer, even if its `laneWrites` bit is set.
- R4: With `stall` low and no recovery load, the counter advances by the number of valid writer lanes, and `nextId` shows the new value in the same cycle.
- R5: With `stall` high the counter keeps its value. The lane identifiers and `nextId` are still shown for the presented group.
- R6: The highest identifier is 2M-1. If the counter plus the number of writers exceeds 2M-1, every lane identifier and `nextId` is reduced by M. At M=256 a counter of 508 with four writers gives 253, 254, 255, 256 and a next value of 256.
- R7: `clearSat` is high only in a cycle where the group is accepted and wraps past 2M-1. After such a cycle the counter has its saturation bit set.
- R8: `recoverLoad` loads `recoverId` into the counter on the next edge. It overrides both `stall` and the presented group.
- R9: When `recoverLoad`, `recoverExc` and `recoverWrote` are all high, the counter is loaded with `recoverId` minus 1. With `recoverExc` high and `recoverWrote` low, it is loaded with `recoverId`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Front-end stall; the group is not accepted |
| laneValid | input | LANES | Lane holds an instruction |
| laneWrites | input | LANES | Lane instruction writes a destination register |
| recoverLoad | input | 1 | Load the counter from the recovery identifier |
| recoverExc | input | 1 | The recovery is for an exception |
| recoverWrote | input | 1 | The excepting instruction opened its own state |
| recoverId | input | IDW | Recovery identifier |
| laneIds | output | LANES*IDW | Identifier per lane, lane 0 in the low bits |
| nextId | output | IDW | Counter value after the group |
| clearSat | output | 1 | Pulse: stored identifiers clear their saturation bit |

## Verification
The hardest situation to reach is a wrap point that falls inside a group or exactly at its edge. Counting up from zero would take more than a hundred full groups to get there. The bench instead uses the recovery load to place the counter at 508 or 510, then presents groups whose writers land before, on, and past 2M-1. One such group is presented while stalled, to confirm that the wrapped identifiers are shown but no clear pulse is raised.

// File: rtl/stid_pkg.sv
package stid_pkg;
  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic advance;  // group accepted, commit the following value
    logic load;     // recovery load of the counter
    logic rebase;   // group runs past the top, lower by M
  } stid_strobe_t;
endpackage

// File: rtl/stid_ctrl.sv
module stid_ctrl
  import stid_pkg::*;
#(
  parameter int IDW = 9
) (
  input  logic           stall,
  input  logic           recoverLoad,
  input  logic           recoverExc,
  input  logic           recoverWrote,
  input  logic [IDW-1:0] recoverId,
  input  logic           pastTop,
  output stid_strobe_t   str,
  output logic [IDW-1:0] loadVal,
  output logic           clearSat
);
  always_comb begin
    str.load    = recoverLoad;
    str.advance = !stall && !recoverLoad;
    str.rebase  = pastTop;
    // exception on a state-opening instruction restarts one state earlier
    loadVal  = (recoverExc && recoverWrote) ? recoverId - IDW'(1) : recoverId;
    clearSat = str.advance && pastTop;
  end
endmodule

// File: rtl/stid_datapath.sv
module stid_datapath
  import stid_pkg::*;
#(
  parameter int NUM_PREGS = 256,
  parameter int LANES     = 4,
  parameter int IDW       = $clog2(NUM_PREGS) + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LANES-1:0]     laneValid,
  input  logic [LANES-1:0]     laneWrites,
  input  stid_strobe_t         str,
  input  logic [IDW-1:0]       loadVal,
  output logic [LANES*IDW-1:0] laneIds,
  output logic [IDW-1:0]       nextId,
  output logic [IDW-1:0]       curId,
  output logic                 pastTop
);
  localparam int CW  = $clog2(LANES + 1);
  localparam int EW  = IDW + 1;
  localparam logic [EW-1:0] TOP_ID = EW'(2 * NUM_PREGS - 1);
  localparam logic [EW-1:0] SPAN   = EW'(NUM_PREGS);

  logic [IDW-1:0] sc;
  logic [CW-1:0]  rank [LANES];
  logic [EW-1:0]  rawNext;

  // running count of writer lanes up to each lane
  always_comb begin
    logic [CW-1:0] acc;
    acc = '0;
    for (int i = 0; i < LANES; i++) begin
      if (laneValid[i] && laneWrites[i]) acc = acc + CW'(1);
      rank[i] = acc;
    end
  end

  assign rawNext = {1'b0, sc} + EW'(rank[LANES-1]);
  assign pastTop = rawNext > TOP_ID;
  assign nextId  = str.rebase ? IDW'(rawNext - SPAN) : IDW'(rawNext);
  assign curId   = sc;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [EW-1:0] raw;
      assign raw = {1'b0, sc} + EW'(rank[g]);
      assign laneIds[g*IDW +: IDW] = str.rebase ? IDW'(raw - SPAN) : IDW'(raw);
      if (g > 0) begin : g_ord
        // R2: identifiers never decrease along program order within a group
        always_comb
          a_r2_lane_order: assert (!rstN ||
              laneIds[g*IDW +: IDW] >= laneIds[(g-1)*IDW +: IDW]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)            sc <= '0;
    else if (str.load)    sc <= loadVal;
    else if (str.advance) sc <= nextId;
  end

  // R6: a group that is not rebased never ends below where it started
  a_r6_no_backstep: assert property (@(posedge clk) disable iff (!rstN)
    (str.advance && !str.rebase) |-> nextId >= sc);
endmodule

// File: rtl/stid_alloc.sv
module stid_alloc
  import stid_pkg::*;
#(
  parameter  int NUM_PREGS = 256,
  parameter  int LANES     = 4,
  localparam int IDW       = $clog2(NUM_PREGS) + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stall,
  input  logic [LANES-1:0]     laneValid,
  input  logic [LANES-1:0]     laneWrites,
  input  logic                 recoverLoad,
  input  logic                 recoverExc,
  input  logic                 recoverWrote,
  input  logic [IDW-1:0]       recoverId,
  output logic [LANES*IDW-1:0] laneIds,
  output logic [IDW-1:0]       nextId,
  output logic                 clearSat
);
  stid_strobe_t   str;
  logic [IDW-1:0] loadVal;
  logic [IDW-1:0] curId;
  logic           pastTop;

  stid_ctrl #(.IDW(IDW)) u_ctrl (
    .stall(stall), .recoverLoad(recoverLoad), .recoverExc(recoverExc),
    .recoverWrote(recoverWrote), .recoverId(recoverId), .pastTop(pastTop),
    .str(str), .loadVal(loadVal), .clearSat(clearSat)
  );

  stid_datapath #(.NUM_PREGS(NUM_PREGS), .LANES(LANES), .IDW(IDW)) u_dp (
    .clk(clk), .rstN(rstN), .laneValid(laneValid), .laneWrites(laneWrites),
    .str(str), .loadVal(loadVal), .laneIds(laneIds), .nextId(nextId),
    .curId(curId), .pastTop(pastTop)
  );

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !recoverLoad) |=> curId == $past(curId));

  a_r8_branch_load: assert property (@(posedge clk) disable iff (!rstN)
    (recoverLoad && !recoverExc) |=> curId == $past(recoverId));

  a_r9_exc_load: assert property (@(posedge clk) disable iff (!rstN)
    (recoverLoad && recoverExc && recoverWrote) |=> curId == $past(recoverId) - IDW'(1));

  a_r7_sat_after_clear: assert property (@(posedge clk) disable iff (!rstN)
    clearSat |=> curId[IDW-1]);

  a_r7_clear_needs_accept: assert property (@(posedge clk) disable iff (!rstN)
    clearSat |-> (!stall && !recoverLoad && nextId[IDW-1]));
endmodule

// File: tb/stid_alloc_tb.sv
module stid_alloc_tb;
  localparam int W = 9;
  localparam int L = 4;
  localparam int NV = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stall = 1'b0;
  logic [L-1:0] laneValid = '0;
  logic [L-1:0] laneWrites = '0;
  logic recoverLoad = 1'b0, recoverExc = 1'b0, recoverWrote = 1'b0;
  logic [W-1:0] recoverId = '0;
  logic [L*W-1:0] laneIds;
  logic [W-1:0] nextId;
  logic clearSat;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stid_alloc u_dut (
    .clk(clk), .rstN(rstN), .stall(stall), .laneValid(laneValid),
    .laneWrites(laneWrites), .recoverLoad(recoverLoad), .recoverExc(recoverExc),
    .recoverWrote(recoverWrote), .recoverId(recoverId), .laneIds(laneIds),
    .nextId(nextId), .clearSat(clearSat)
  );

  // {stall, valid, writes (bit i = lane i), id0, id1, id2, id3, next, clear}
  localparam logic [54:0] VEC [NV] = '{
    {1'b0, 4'b1111, 4'b0000, 9'd0, 9'd0, 9'd0, 9'd0,  9'd0,  1'b0},
    {1'b0, 4'b1111, 4'b0101, 9'd1, 9'd1, 9'd2, 9'd2,  9'd2,  1'b0},
    {1'b0, 4'b1111, 4'b1111, 9'd3, 9'd4, 9'd5, 9'd6,  9'd6,  1'b0},
    {1'b1, 4'b1111, 4'b1111, 9'd7, 9'd8, 9'd9, 9'd10, 9'd10, 1'b0},
    {1'b0, 4'b0011, 4'b1111, 9'd7, 9'd8, 9'd8, 9'd8,  9'd8,  1'b0},
    {1'b0, 4'b1111, 4'b1000, 9'd8, 9'd8, 9'd8, 9'd9,  9'd9,  1'b0}
  };

  function automatic string vecTag(input int i);
    case (i)
      0: return "R1 no writers";
      1: return "R2 mixed lanes";
      2: return "R4 all writers";
      3: return "R5 stalled group";
      4: return "R3 masked lanes";
      5: return "R2 last lane writer";
      default: return "?";
    endcase
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic checkOut(input string tag, input logic [L*W-1:0] expIds,
                          input logic [W-1:0] expNext, input logic expClear);
    checks++;
    if (laneIds !== expIds) begin
      fails++;
      $display("FAIL %s laneIds actual %h expected %h", tag, laneIds, expIds);
    end
    checks++;
    if (nextId !== expNext) begin
      fails++;
      $display("FAIL %s nextId actual %0d expected %0d", tag, nextId, expNext);
    end
    checks++;
    if (clearSat !== expClear) begin
      fails++;
      $display("FAIL %s clearSat actual %0b expected %0b", tag, clearSat, expClear);
    end
  endtask

  task automatic present(input logic s, input logic [L-1:0] v, input logic [L-1:0] w);
    @(negedge clk);
    stall = s; laneValid = v; laneWrites = w;
    #1;
  endtask

  task automatic recover(input logic [W-1:0] id, input logic exc, input logic wrote);
    @(negedge clk);
    recoverLoad = 1'b1; recoverId = id; recoverExc = exc; recoverWrote = wrote;
    stall = 1'b1; laneValid = 4'b1111; laneWrites = 4'b1111;
    @(negedge clk);
    recoverLoad = 1'b0; recoverExc = 1'b0; recoverWrote = 1'b0;
  endtask

  function automatic logic [L*W-1:0] ids(input int a, input int b, input int c, input int d);
    return {W'(d), W'(c), W'(b), W'(a)};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    present(1'b0, 4'b1111, 4'b0000);
    checkOut("R1 reset", ids(0, 0, 0, 0), 9'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      present(VEC[i][54], VEC[i][53:50], VEC[i][49:46]);
      checkOut(vecTag(i), {VEC[i][18:10], VEC[i][27:19], VEC[i][36:28], VEC[i][45:37]},
               VEC[i][9:1], VEC[i][0]);
    end

    // R8: load overrides stall and the presented writers (counter was 9)
    recover(9'd508, 1'b0, 1'b0);
    present(1'b0, 4'b1111, 4'b0000);
    checkOut("R8 recovery load", ids(508, 508, 508, 508), 9'd508, 1'b0);

    // R6 R7: wrap inside a group of four writers
    present(1'b0, 4'b1111, 4'b1111);
    checkOut("R6 wrap mid group", ids(253, 254, 255, 256), 9'd256, 1'b1);
    present(1'b0, 4'b1111, 4'b0000);
    checkOut("R7 after wrap", ids(256, 256, 256, 256), 9'd256, 1'b0);

    // R6: reaching the top exactly does not wrap
    recover(9'd510, 1'b0, 1'b0);
    present(1'b0, 4'b1111, 4'b0001);
    checkOut("R6 reach top", ids(511, 511, 511, 511), 9'd511, 1'b0);
    present(1'b0, 4'b1111, 4'b0001);
    checkOut("R6 wrap at lane 0", ids(256, 256, 256, 256), 9'd256, 1'b1);

    // R7: stalled wrapping group shows wrapped ids but raises no pulse
    recover(9'd510, 1'b0, 1'b0);
    present(1'b1, 4'b1111, 4'b1111);
    checkOut("R7 stalled wrap", ids(255, 256, 257, 258), 9'd258, 1'b0);
    present(1'b0, 4'b1111, 4'b0000);
    checkOut("R5 held at 510", ids(510, 510, 510, 510), 9'd510, 1'b0);

    // R9: exception recovery
    recover(9'd300, 1'b1, 1'b1);
    present(1'b0, 4'b1111, 4'b0000);
    checkOut("R9 exc wrote", ids(299, 299, 299, 299), 9'd299, 1'b0);
    recover(9'd300, 1'b1, 1'b0);
    present(1'b0, 4'b1111, 4'b0000);
    checkOut("R9 exc no write", ids(300, 300, 300, 300), 9'd300, 1'b0);

    // R3: invalid writer lanes do not advance the counter
    present(1'b0, 4'b0000, 4'b1111);
    checkOut("R3 all invalid", ids(300, 300, 300, 300), 9'd300, 1'b0);
    present(1'b0, 4'b1111, 4'b0000);
    checkOut("R3 counter unchanged", ids(300, 300, 300, 300), 9'd300, 1'b0);

    done = 1'b1;
    summary();
  end
endmodule